// File: doc/BRIEF.md
# Masked Level and Edge Trigger

This block watches a stream of 16-channel logic samples and raises a trigger when every channel chosen by a mask meets its own condition. Each channel's condition is one of two kinds. A level condition asks only that the channel equal a wanted value. An edge condition asks that the channel has just changed into that value. Only samples that arrive with the valid strobe are examined.

Two 32-bit words set the trigger up. The select word carries the wanted value of each channel in its low half and the level-or-edge choice in its high half. The control word carries the participation mask in its high half and an enable flag in bit 2. The output flag is sticky. Once it rises it stays high for as long as the enable flag stays high. Clearing the enable drops it. Any logic for pre-trigger storage or capture memory sits outside this block.

Top module: `chan_trigger`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `trig_hit` is 0 and no previous sample is held.
- R2: A level channel (select bit 16+i = 0) matches a valid sample whose bit i equals select bit i. When every masked channel matches and `ctl_word[2]` = 1, `trig_hit` is 1 after the clock edge that takes that sample.
- R3: An edge channel (select bit 16+i = 1) matches only when its bit in the current valid sample differs from its bit in the previous valid sample and equals select bit i. This covers both rising and falling edges.
- R4: Channels whose mask bit `ctl_word[16+i]` is 0 never prevent a match, whatever their data.
- R5: With `ctl_word[31:16]` = 0 and the trigger enabled, the first valid sample sets `trig_hit`.
- R6: After `trig_hit` is set it stays 1 while `ctl_word[2]` = 1. An edge taken with `ctl_word[2]` = 0 clears it. While disabled, matching samples do not set it. The other low control bits do not enable it.
- R7: A sample with `smp_valid` = 0 neither fires the trigger nor replaces the stored previous sample.
- R8: An edge channel cannot match on the first valid sample after reset, because no previous sample exists yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | 16 | Current logic sample, one bit per channel |
| smp_valid | input | 1 | High when `smp_data` holds a new sample |
| sel_word | input | 32 | [15:0] wanted values, [31:16] edge-mode flags |
| ctl_word | input | 32 | [31:16] channel mask, [2] trigger enable |
| trig_hit | output | 1 | Sticky trigger flag |

## Verification
The state that can go wrong is the stored previous sample and its "history present" flag. Either fault appears at `trig_hit` only through edge channels. A history that updates on invalid samples, or that is not cleared by reset, makes an edge trigger fire one sample early or not at all. This shows on the first valid sample after the faulty update. A sticky flag that loses its state shows as `trig_hit` falling one cycle after a non-matching sample while still enabled. A flag that survives disable shows one cycle after the enable bit drops.

// File: rtl/chan_trig_pkg.sv
package chan_trig_pkg;

    typedef enum logic {
        MODE_LEVEL = 1'b0,
        MODE_EDGE  = 1'b1
    } chan_mode_e;

    typedef struct packed {
        logic cur;
        logic prev;
        logic hist_ok;
    } chan_obs_t;

    // one channel's verdict; unmasked channels always agree
    function automatic logic chan_ok(
        input logic       in_mask,
        input chan_mode_e mode,
        input logic       want,
        input chan_obs_t  obs
    );
        logic lvl;
        lvl = (obs.cur == want);
        if (!in_mask)
            return 1'b1;
        if (mode == MODE_EDGE)
            return lvl && obs.hist_ok && (obs.prev != obs.cur);
        return lvl;
    endfunction

endpackage

// File: rtl/trig_sample_hist.sv
module trig_sample_hist #(
    parameter int unsigned NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] smp_data,
    input  logic           smp_valid,
    output logic [NCH-1:0] prev_data,
    output logic           hist_ok
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_data <= '0;
            hist_ok   <= 1'b0;
        end else if (smp_valid) begin
            prev_data <= smp_data;
            hist_ok   <= 1'b1;
        end
    end
endmodule

// File: rtl/trig_chan_match.sv
module trig_chan_match
    import chan_trig_pkg::*;
#(
    parameter int unsigned NCH = 16
) (
    input  logic [NCH-1:0] cur_data,
    input  logic [NCH-1:0] prev_data,
    input  logic           hist_ok,
    input  logic [NCH-1:0] want,
    input  logic [NCH-1:0] edge_sel,
    input  logic [NCH-1:0] mask,
    output logic           all_ok
);
    logic [NCH-1:0] per_ok;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chan_obs_t  obs;
        chan_mode_e mode;
        always_comb begin
            obs.cur     = cur_data[i];
            obs.prev    = prev_data[i];
            obs.hist_ok = hist_ok;
            mode        = edge_sel[i] ? MODE_EDGE : MODE_LEVEL;
            per_ok[i]   = chan_ok(mask[i], mode, want[i], obs);
        end
    end

    assign all_ok = &per_ok;
endmodule

// File: rtl/trig_latch.sv
module trig_latch (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic fire,
    output logic hit
);
    always_ff @(posedge clk) begin
        if (rst || !enable)
            hit <= 1'b0;
        else if (fire)
            hit <= 1'b1;
    end
endmodule

// File: rtl/chan_trigger.sv
module chan_trigger #(
    parameter int unsigned NCH    = 16,
    parameter int unsigned EN_POS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   smp_data,
    input  logic             smp_valid,
    input  logic [2*NCH-1:0] sel_word,
    input  logic [2*NCH-1:0] ctl_word,
    output logic             trig_hit
);
    localparam int unsigned CW = 2 * NCH;

    logic [NCH-1:0] want, edge_sel, mask, prev_data;
    logic           hist_ok, all_ok, enable, fire;

    assign want     = sel_word[NCH-1:0];
    assign edge_sel = sel_word[CW-1:NCH];
    assign mask     = ctl_word[CW-1:NCH];
    assign enable   = ctl_word[EN_POS];

    trig_sample_hist #(.NCH(NCH)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .smp_data  (smp_data),
        .smp_valid (smp_valid),
        .prev_data (prev_data),
        .hist_ok   (hist_ok)
    );

    trig_chan_match #(.NCH(NCH)) u_match (
        .cur_data  (smp_data),
        .prev_data (prev_data),
        .hist_ok   (hist_ok),
        .want      (want),
        .edge_sel  (edge_sel),
        .mask      (mask),
        .all_ok    (all_ok)
    );

    assign fire = smp_valid && all_ok;

    trig_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .fire   (fire),
        .hit    (trig_hit)
    );
endmodule

// File: rtl/trig_chk.sv
module trig_chk #(
    parameter int unsigned NCH    = 16,
    parameter int unsigned EN_POS = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_valid,
    input logic [2*NCH-1:0] ctl_word,
    input logic             trig_hit
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !trig_hit);

    // R6
    disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_word[EN_POS] |=> !trig_hit);

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_hit && ctl_word[EN_POS]) |=> trig_hit);

    // R7
    rise_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_hit) |-> ($past(smp_valid) && $past(ctl_word[EN_POS])));

    // R5
    empty_mask_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_word[EN_POS] && ctl_word[2*NCH-1:NCH] == '0 && smp_valid) |=> trig_hit);
endmodule

bind chan_trigger trig_chk #(.NCH(NCH), .EN_POS(EN_POS)) u_trig_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .ctl_word  (ctl_word),
    .trig_hit  (trig_hit)
);

// File: tb/chan_trigger_test.sv
module chan_trigger_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] smp_data = '0;
    logic        smp_valid = 1'b0;
    logic [31:0] sel_word = '0;
    logic [31:0] ctl_word = '0;
    logic        trig_hit;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_trigger uut (
        .clk       (clk),
        .rst       (rst),
        .smp_data  (smp_data),
        .smp_valid (smp_valid),
        .sel_word  (sel_word),
        .ctl_word  (ctl_word),
        .trig_hit  (trig_hit)
    );

    task automatic chk(input string req, input logic exp);
        n_chk++;
        if (trig_hit !== exp) begin
            n_fail++;
            $display("FAIL %s: trig_hit=%b expected %b", req, trig_hit, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_valid = 1'b0; ctl_word = '0; sel_word = '0;
        @(posedge clk); @(posedge clk); #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg(input logic [31:0] s, input logic [31:0] c);
        @(negedge clk);
        smp_valid = 1'b0;
        sel_word  = s;
        ctl_word  = c;
    endtask

    task automatic step(input logic [15:0] d, input logic v);
        @(negedge clk);
        smp_data = d; smp_valid = v;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        do_reset();
        @(posedge clk); #1;
        chk("R1 after reset", 1'b0);
    endtask

    task automatic t_level();
        do_reset();
        cfg({16'h0000, 16'h00A5}, {16'h00FF, 16'h0004});
        step(16'h0000, 1'b1); chk("R2 level mismatch", 1'b0);
        step(16'h00A5, 1'b0); chk("R7 invalid level match", 1'b0);
        step(16'hFFA5, 1'b1); chk("R2/R4 level match, unmasked differ", 1'b1);
        step(16'h1234, 1'b1); chk("R6 sticky on mismatch", 1'b1);
        step(16'h0000, 1'b0); chk("R6 sticky idle", 1'b1);
        cfg({16'h0000, 16'h00A5}, 32'h0000_0000);
        step(16'h0000, 1'b0); chk("R6 disable clears", 1'b0);
        cfg({16'h0000, 16'h00A5}, {16'h00FF, 16'h000B});
        step(16'h00A5, 1'b1); chk("R6 no fire while disabled", 1'b0);
    endtask

    task automatic t_edge_rise();
        do_reset();
        cfg({16'h0001, 16'h0001}, {16'h0001, 16'h0004});
        step(16'h0001, 1'b1); chk("R8 no edge without history", 1'b0);
        step(16'h0001, 1'b1); chk("R3 no change no edge", 1'b0);
        step(16'h0000, 1'b1); chk("R3 edge to wrong value", 1'b0);
        step(16'h0001, 1'b1); chk("R3 rising edge", 1'b1);
    endtask

    task automatic t_edge_fall();
        do_reset();
        cfg({16'h0001, 16'h0000}, {16'h0001, 16'h0004});
        step(16'h0001, 1'b1); chk("R3 high before fall", 1'b0);
        step(16'h0000, 1'b1); chk("R3 falling edge", 1'b1);
    endtask

    task automatic t_mixed();
        do_reset();
        cfg({16'h0001, 16'h0003}, {16'h0003, 16'h0004});
        step(16'h0000, 1'b1); chk("R2 mixed idle", 1'b0);
        step(16'h0001, 1'b1); chk("R3 edge ok level not", 1'b0);
        step(16'h0000, 1'b1); chk("R3 mixed back low", 1'b0);
        step(16'h0003, 1'b1); chk("R2/R3 edge and level", 1'b1);
    endtask

    task automatic t_invalid_hist();
        do_reset();
        cfg({16'h0001, 16'h0001}, {16'h0001, 16'h0004});
        step(16'h0000, 1'b1); chk("R7 prime history", 1'b0);
        step(16'h0001, 1'b0); chk("R7 invalid edge ignored", 1'b0);
        step(16'h0001, 1'b1); chk("R7 history kept over invalid", 1'b1);
    endtask

    task automatic t_empty();
        do_reset();
        cfg(32'hFFFF_FFFF, 32'h0000_0004);
        step(16'h0000, 1'b0); chk("R5 no valid no fire", 1'b0);
        step(16'h5555, 1'b1); chk("R5 empty mask fires", 1'b1);
    endtask

    initial begin
        t_reset();
        t_level();
        t_edge_rise();
        t_edge_fall();
        t_mixed();
        t_invalid_hist();
        t_empty();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule